// File: doc/BRIEF.md
# Sized Adder-Subtractor with Extend Flag

This block is the combinational add/subtract datapath of an integer execution unit. It adds or subtracts two operands at byte, word or long size and forms five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). It offers three forms of the operation:

- A plain form.
- An extended form, which also folds in the incoming extend bit. This lets multi-precision values be built by chaining operations.
- A quick form, which replaces the source with a small immediate from 1 to 8.

Only the low bits chosen by the size field take part in the arithmetic. The destination bits above that size pass through to the result unchanged. When the destination is an address register, a suppress input holds every flag at its incoming value. Operand fetch and instruction decode are done elsewhere. The block takes the operation code, the size, both operands, the quick field and the current flags, and returns the result and the new flags in the same cycle.

Top module: `addsub_unit`

## Requirements
- R1: Addition writes dst+src over the low 8/16/32 bits selected by the size. Result bits above that size equal the destination operand's bits.
- R2: Subtraction writes dst−src over the sized bits. C is the borrow out of the sized field: 1 when the unsigned source (plus X in extended form) exceeds the unsigned destination.
- R3: V is set exactly when the sized two's complement result falls outside the signed range of that size.
- R4: N equals the top bit of the sized result. Z is 1 exactly when all sized result bits are 0.
- R5: Whenever flags are updated, X takes the same value as C.
- R6: The extended add computes dst+src+Xin. The extended subtract computes dst−src−Xin, where Xin is flagsIn[4]. The plain and quick forms ignore Xin.
- R7: In the quick form the source is the 3-bit quickImm, with 0 meaning 8 and 1 to 7 taken as is. srcOperand is then ignored.
- R8: With addrDest=1, flagsOut equals flagsIn, and the result is still computed as usual.
- R9: Size encoding: 00 is byte, 01 is word, 10 and 11 are long.
- R10: Operation encoding: 0 add, 1 sub, 2 add-extended, 3 sub-extended, 4 add-quick, 5 sub-quick. Codes 6 and 7 act as plain add. The flag vector is packed as bit4=X, bit3=N, bit2=Z, bit1=V, bit0=C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 3 | Operation code (R10) |
| sizeSel | input | 2 | Operand size (R9) |
| srcOperand | input | 32 | Source operand |
| dstOperand | input | 32 | Destination operand; supplies the unsized upper result bits |
| quickImm | input | 3 | Quick immediate field, 0 meaning 8 |
| flagsIn | input | 5 | Current flags {X,N,Z,V,C} |
| addrDest | input | 1 | Destination is an address register; suppresses flag update |
| result | output | 32 | Sized sum or difference merged with the destination's upper bits |
| flagsOut | output | 5 | New flags {X,N,Z,V,C} |

## Verification
The bench targets the sign boundaries of each size: 0x7F+1 and 0x80−1 at byte size, and the matching values at word and long size. A unit that took overflow from the wrong bit would get V wrong at exactly these points. Extended operations are run with X set and with X clear, because a datapath that drops the incoming X gives a result off by one only in the X=1 case. Both quick encodings, 0 for 8 and 7 as is, are applied with a nonzero srcOperand, which exposes a decoder that uses the source or treats zero as zero. Suppressed runs start from flag patterns the arithmetic would change, so a unit that writes the flags anyway is caught at the output.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int FLAG_W = 5;
  localparam int FX = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDX = 3'd2,
    OP_SUBX = 3'd3,
    OP_ADDQ = 3'd4,
    OP_SUBQ = 3'd5
  } opKind_e;

  typedef struct packed {
    logic doSub;
    logic useExtend;
    logic useQuick;
  } opStrobes_t;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic [2:0]  opSel,
  output opStrobes_t  strobes
);
  always_comb begin
    strobes = '0;
    case (opSel)
      OP_SUB:  strobes.doSub = 1'b1;
      OP_ADDX: strobes.useExtend = 1'b1;
      OP_SUBX: begin strobes.doSub = 1'b1; strobes.useExtend = 1'b1; end
      OP_ADDQ: strobes.useQuick = 1'b1;
      OP_SUBQ: begin strobes.doSub = 1'b1; strobes.useQuick = 1'b1; end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LANE_COUNT = 3,
  parameter int QUICK_W    = 3
) (
  input  opStrobes_t         strobes,
  input  logic [1:0]         sizeSel,
  input  logic [DATA_W-1:0]  srcOperand,
  input  logic [DATA_W-1:0]  dstOperand,
  input  logic [QUICK_W-1:0] quickImm,
  input  logic [FLAG_W-1:0]  flagsIn,
  input  logic               addrDest,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_W-1:0]  flagsOut
);
  localparam int QV_W = QUICK_W + 1;
  localparam int LANE_IDX_W = (LANE_COUNT > 1) ? $clog2(LANE_COUNT) : 1;

  logic [QV_W-1:0]   quickVal;
  logic [DATA_W-1:0] srcEff;
  logic              extIn;

  always_comb begin
    quickVal = (quickImm == '0) ? QV_W'(1 << QUICK_W) : {1'b0, quickImm};
    srcEff   = strobes.useQuick ? DATA_W'(quickVal) : srcOperand;
    extIn    = strobes.useExtend & flagsIn[FX];
  end

  logic [DATA_W-1:0] laneRes   [LANE_COUNT];
  logic              laneCarry [LANE_COUNT];
  logic              laneOvf   [LANE_COUNT];
  logic              laneNeg   [LANE_COUNT];
  logic              laneZero  [LANE_COUNT];

  for (genvar g = 0; g < LANE_COUNT; g++) begin : gLane
    localparam int W = 8 << g;
    logic [W-1:0] opA, opB, sized;
    logic [W:0]   wide;

    always_comb begin
      opA = dstOperand[W-1:0];
      opB = srcEff[W-1:0];
      if (strobes.doSub) wide = {1'b0, opA} - {1'b0, opB} - {{W{1'b0}}, extIn};
      else               wide = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, extIn};
      sized = wide[W-1:0];
    end

    assign laneCarry[g] = wide[W];
    assign laneNeg[g]   = sized[W-1];
    assign laneZero[g]  = (sized == '0);
    assign laneOvf[g]   = strobes.doSub
                        ? ((opA[W-1] != opB[W-1]) && (sized[W-1] != opA[W-1]))
                        : ((opA[W-1] == opB[W-1]) && (sized[W-1] != opA[W-1]));

    if (W >= DATA_W) begin : gFull
      assign laneRes[g] = sized[DATA_W-1:0];
    end else begin : gPart
      assign laneRes[g] = {dstOperand[DATA_W-1:W], sized};
    end
  end

  logic [LANE_IDX_W-1:0] laneSel;
  always_comb begin
    if (int'(sizeSel) >= LANE_COUNT) laneSel = LANE_IDX_W'(LANE_COUNT - 1);
    else                            laneSel = LANE_IDX_W'(sizeSel);
  end

  always_comb begin
    result = laneRes[laneSel];
    if (addrDest) begin
      flagsOut = flagsIn;
    end else begin
      flagsOut[FX] = laneCarry[laneSel];
      flagsOut[FN] = laneNeg[laneSel];
      flagsOut[FZ] = laneZero[laneSel];
      flagsOut[FV] = laneOvf[laneSel];
      flagsOut[FC] = laneCarry[laneSel];
    end
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int QUICK_W = 3
) (
  input  logic [2:0]         opSel,
  input  logic [1:0]         sizeSel,
  input  logic [DATA_W-1:0]  srcOperand,
  input  logic [DATA_W-1:0]  dstOperand,
  input  logic [QUICK_W-1:0] quickImm,
  input  logic [4:0]         flagsIn,
  input  logic               addrDest,
  output logic [DATA_W-1:0]  result,
  output logic [4:0]         flagsOut
);
  opStrobes_t strobes;

  addsub_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  addsub_datapath #(
    .DATA_W     (DATA_W),
    .LANE_COUNT (3),
    .QUICK_W    (QUICK_W)
  ) u_dp (
    .strobes    (strobes),
    .sizeSel    (sizeSel),
    .srcOperand (srcOperand),
    .dstOperand (dstOperand),
    .quickImm   (quickImm),
    .flagsIn    (flagsIn),
    .addrDest   (addrDest),
    .result     (result),
    .flagsOut   (flagsOut)
  );
endmodule

// File: rtl/addsub_checker.sv
module addsub_checker (
  input logic [2:0]  opSel,
  input logic [1:0]  sizeSel,
  input logic [31:0] dstOperand,
  input logic [4:0]  flagsIn,
  input logic        addrDest,
  input logic [31:0] result,
  input logic [4:0]  flagsOut
);
  always_comb begin
    if (addrDest) begin
      assert_flags_held_R8: assert (flagsOut == flagsIn);
    end
    if (!addrDest) begin
      assert_x_tracks_c_R5: assert (flagsOut[4] == flagsOut[0]);
    end
    if (sizeSel == 2'b00) begin
      assert_byte_upper_kept_R1: assert (result[31:8] == dstOperand[31:8]);
    end
    if (sizeSel == 2'b01) begin
      assert_word_upper_kept_R9: assert (result[31:16] == dstOperand[31:16]);
    end
    if (!addrDest && sizeSel == 2'b00) begin
      assert_byte_sign_R4: assert (flagsOut[3] == result[7]);
    end
    if (!addrDest && sizeSel[1]) begin
      assert_long_zero_R4: assert (flagsOut[2] == (result == 32'd0));
    end
    if (opSel == 3'd0 && !addrDest && flagsOut[1]) begin
      assert_no_overflow_R3: assert (!(sizeSel == 2'b00 && dstOperand[7] != result[7] && flagsOut[0] && !dstOperand[7]));
    end
  end
endmodule

bind addsub_unit addsub_checker u_addsub_checker (
  .opSel      (opSel),
  .sizeSel    (sizeSel),
  .dstOperand (dstOperand),
  .flagsIn    (flagsIn),
  .addrDest   (addrDest),
  .result     (result),
  .flagsOut   (flagsOut)
);

// File: tb/test_addsub_unit.sv
module test_addsub_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opSel = '0;
  logic [1:0]  sizeSel = '0;
  logic [31:0] srcOperand = '0;
  logic [31:0] dstOperand = '0;
  logic [2:0]  quickImm = '0;
  logic [4:0]  flagsIn = '0;
  logic        addrDest = 1'b0;
  logic [31:0] result;
  logic [4:0]  flagsOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  addsub_unit i_addsub_unit (
    .opSel(opSel), .sizeSel(sizeSel), .srcOperand(srcOperand), .dstOperand(dstOperand),
    .quickImm(quickImm), .flagsIn(flagsIn), .addrDest(addrDest),
    .result(result), .flagsOut(flagsOut)
  );

  function automatic logic [36:0] model(logic [2:0] op, logic [1:0] sz, logic [31:0] s,
                                        logic [31:0] d, logic [2:0] q, logic [4:0] fi, logic ad);
    longint w, span, mask, ua, ub, xi, ur, sa, sb, sr;
    logic isSub, isExt, isQ, cy, ov, neg, zer;
    logic [31:0] res;
    w     = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    span  = longint'(1) << w;
    mask  = span - 1;
    isSub = (op == 3'd1) || (op == 3'd3) || (op == 3'd5);
    isExt = (op == 3'd2) || (op == 3'd3);
    isQ   = (op == 3'd4) || (op == 3'd5);
    ua = longint'(d) & mask;
    ub = isQ ? ((q == 3'd0) ? 8 : longint'(q)) : (longint'(s) & mask);
    xi = (isExt && fi[4]) ? 1 : 0;
    ur = isSub ? (ua - ub - xi) : (ua + ub + xi);
    cy = isSub ? (ur < 0) : (ur > mask);
    sa = (ua >= span / 2) ? ua - span : ua;
    sb = (ub >= span / 2) ? ub - span : ub;
    sr = isSub ? (sa - sb - xi) : (sa + sb + xi);
    ov = (sr < -(span / 2)) || (sr >= span / 2);
    ur = ur & mask;
    neg = (ur >= span / 2);
    zer = (ur == 0);
    res = 32'((longint'(d) & ~mask) | ur);
    if (ad) return {res, fi};
    return {res, cy, neg, zer, ov, cy};
  endfunction

  task automatic apply(string tag, logic [2:0] op, logic [1:0] sz, logic [31:0] s,
                       logic [31:0] d, logic [2:0] q, logic [4:0] fi, logic ad);
    logic [36:0] exp;
    @(negedge clk);
    opSel = op; sizeSel = sz; srcOperand = s; dstOperand = d;
    quickImm = q; flagsIn = fi; addrDest = ad;
    #5;
    exp = model(op, sz, s, d, q, fi, ad);
    checks++;
    if (result !== exp[36:5]) begin
      fails++;
      $display("FAIL %s result op=%0d sz=%0d actual=%h expected=%h", tag, op, sz, result, exp[36:5]);
    end
    checks++;
    if (flagsOut !== exp[4:0]) begin
      fails++;
      $display("FAIL %s flags op=%0d sz=%0d actual=%b expected=%b", tag, op, sz, flagsOut, exp[4:0]);
    end
  endtask

  task automatic literal(string tag, logic [31:0] actRes, logic [31:0] expRes,
                         logic [4:0] actF, logic [4:0] expF);
    checks++;
    if (actRes !== expRes || actF !== expF) begin
      fails++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", tag, actRes, actF, expRes, expF);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state, all inputs zero: sum 0, Z set (R4)
    apply("R4_idle", 3'd0, 2'd0, 0, 0, 0, 5'b0, 0);
    literal("R4_idle_lit", result, 32'h0, flagsOut, 5'b00100);
    // worked byte examples (R1 R2 R3)
    apply("R1_R3_byte_add", 3'd0, 2'd0, 32'h6B, 32'h5A, 0, 0, 0);
    literal("R1_R3_byte_add_lit", result, 32'hC5, flagsOut, 5'b01010);
    apply("R2_byte_sub", 3'd1, 2'd0, 32'h6B, 32'h5A, 0, 0, 0);
    literal("R2_R5_byte_sub_lit", result, 32'hEF, flagsOut, 5'b11001);
    // upper bits passthrough (R1)
    apply("R1_upper", 3'd0, 2'd0, 32'hFFFF_FF01, 32'hA5A5_A5FF, 0, 0, 0);
    literal("R1_upper_lit", result, 32'hA5A5_A500, flagsOut, 5'b10101);
    // sign boundaries (R3) at each size (R9)
    apply("R3_byte_pos", 3'd0, 2'd0, 1, 32'h7F, 0, 0, 0);
    apply("R3_byte_neg", 3'd1, 2'd0, 1, 32'h80, 0, 0, 0);
    apply("R3_R9_word", 3'd0, 2'd1, 1, 32'h1234_7FFF, 0, 0, 0);
    apply("R3_R9_long", 3'd1, 2'd2, 1, 32'h8000_0000, 0, 0, 0);
    apply("R9_size11", 3'd0, 2'd3, 32'hFFFF_FFFF, 1, 0, 0, 0);
    literal("R9_size11_lit", result, 32'h0, flagsOut, 5'b10101);
    // extended forms with X set and clear (R6)
    apply("R6_addx_x1", 3'd2, 2'd0, 32'hFF, 32'h00, 0, 5'b10000, 0);
    literal("R6_addx_x1_lit", result, 32'h0, flagsOut, 5'b10101);
    apply("R6_addx_x0", 3'd2, 2'd1, 32'h10, 32'h20, 0, 5'b00000, 0);
    apply("R6_subx_x1", 3'd3, 2'd2, 0, 0, 0, 5'b10000, 0);
    literal("R6_subx_x1_lit", result, 32'hFFFF_FFFF, flagsOut, 5'b11001);
    apply("R6_add_ignores_x", 3'd0, 2'd0, 1, 1, 0, 5'b10000, 0);
    literal("R6_add_ignores_x_lit", result, 32'h2, flagsOut, 5'b00000);
    // quick immediate (R7)
    apply("R7_q0", 3'd4, 2'd0, 32'hDEAD_BEEF, 32'h10, 3'd0, 0, 0);
    literal("R7_q0_lit", result, 32'h18, flagsOut, 5'b00000);
    apply("R7_q7", 3'd5, 2'd1, 32'h1234_5678, 32'h7, 3'd7, 0, 0);
    literal("R7_q7_lit", result, 32'h0, flagsOut, 5'b00100);
    // address destination suppresses flags (R8)
    apply("R8_suppress", 3'd1, 2'd0, 32'h6B, 32'h5A, 0, 5'b00110, 1);
    literal("R8_suppress_lit", result, 32'hEF, flagsOut, 5'b00110);
    // undefined codes act as add (R10)
    apply("R10_op6", 3'd6, 2'd0, 3, 4, 0, 5'b10000, 0);
    literal("R10_op6_lit", result, 32'h7, flagsOut, 5'b00000);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      apply($sformatf("R%0d_rand", (op == 3'd1) ? 2 : (op inside {3'd2, 3'd3}) ? 6 :
                      (op inside {3'd4, 3'd5}) ? 7 : 1),
            op, 2'($urandom_range(0, 3)), $urandom(), $urandom(), 3'($urandom()),
            5'($urandom()), ($urandom_range(0, 7) == 0));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule